// File: doc/BRIEF.md
# Replicated-Register Steering Resolver

This block answers one question for a register access path: given a register address, does the access need to be steered to one particular copy of a replicated register, and if so, which group and instance should it go to? Each copy of a replicated register sits in a hardware unit, and that unit may be fused off. An access steered to a missing unit is lost. The resolver sorts every address into one of six steering classes or one implicit class, using small fixed tables of inclusive address ranges. It then returns the steering target for that class, chosen so that the access reaches a unit that is present.

The per-class targets are computed from fuse masks supplied as inputs: memory-slice enables, a cache-bank mask, node enables and compute-subslice enables. They are captured into registers on an initialisation strobe. Lookups are purely combinational against those registers.

A warning output flags an address found in no table, and also a hit on a class whose target has not yet been initialised. A fuse-error flag reports that a required presence mask was all zero at initialisation.

Top module: `steer_resolver`

## Requirements
- R1: Every range includes both its lower and its upper bound. A table entry whose upper bound is zero ends that table, and entries after it are never matched. In particular, the implicit table holds a dead entry 0x002000-0x002FFF after its terminator, so address 0x002100 matches nothing.
- R2: Classes are searched in priority order: bank, mslice, cnode, subslice, pair, base. The first class containing the address drives `steer_req`=1 and that class's group and instance. The tables are:
  - bank: 0x00B100-0x00B3FF and 0x008C80-0x008CFF
  - mslice: 0x00DD00-0x00DDFF and 0x00E900-0x00EFFF
  - cnode: 0x00B000-0x00B0FF and 0x00D880-0x00D8FF
  - subslice: 0x005200-0x0052FF, 0x008140-0x00815F and 0x00DE80-0x00E8FF
  - pair: 0x000B00-0x000BFF and 0x001000-0x001FFF
  - base: 0x004000-0x004AFF and 0x00B000-0x00B3FF
  - implicit: 0x00C800-0x00CFFF and 0x00F000-0x00FFFF
- R3: An address found in no steering class but inside an implicit range gives `steer_req`=0, group 0, instance 0 and `warn`=0.
- R4: An address found in no table at all gives `steer_req`=1, group 0, instance 0 and `warn`=1.
- R5: After reset, only the base class counts as initialised. A hit on any other class before the first `init_stb` raises `warn` but still returns that class's target register (zero after reset). The base target is always group 0, instance 0.
- R6: The mslice target has group = index of the lowest set bit of `mslice_en` and instance 0.
- R7: The cnode target has group = (lowest set `mslice_en` index) shifted left by one, and instance 0.
- R8: The bank target has group = lowest set `mslice_en` index. Its instance is 0 when `bank_mask[0]` is 1, and 2 otherwise.
- R9: With sel = lowest set bit index of `node_en`, the pair target has group = sel >> 1 and instance = sel & 1.
- R10: With d = lowest set bit index of `subslice_en` and P subslices per group, the subslice target has group = d / P and instance = d % P. P is selected by `grp_mode`: 0 gives 4, 1 gives 6, 2 gives 8, and 3 gives 4.
- R11: On `init_stb`, `fuse_err` becomes 1 if `mslice_en`, `node_en` or `subslice_en` is all zero, and 0 otherwise. An all-zero mask yields index 0 in the target formulas.
- R12: Targets and `fuse_err` change only on the clock edge where `init_stb` is 1. Changing the fuse inputs without the strobe leaves every lookup result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_stb | input | 1 | Capture targets from the fuse inputs |
| mslice_en | input | MS_W | Memory-slice presence mask |
| bank_mask | input | BANK_W | Cache-bank presence mask |
| node_en | input | NODE_W | Node presence mask |
| subslice_en | input | SS_W | Compute-subslice presence mask |
| grp_mode | input | 2 | Subslices-per-group selector |
| addr | input | 24 | Register address to classify |
| steer_req | output | 1 | Access must be steered |
| grp_id | output | ID_W | Steering group |
| inst_id | output | ID_W | Steering instance |
| warn | output | 1 | Unknown address or uninitialised class |
| fuse_err | output | 1 | A presence mask was empty at init |

## Verification
Several properties are checked on every cycle:
- an unsteered result is always quiet and zero;
- after the first initialisation, any warning carries the zero fallback target;
- the fuse-error flag follows the masks at each strobe and holds between strobes.

The bench's scenarios are needed for the rest: the range priority where tables overlap, the inclusive bounds and the terminator, the per-class target arithmetic for chosen and random masks, and the pre-initialisation warnings. These are compared against a bench model over boundary-biased random addresses.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int ADDR_W      = 24;
    localparam int ID_W        = 8;
    localparam int NUM_TYPES   = 6;
    localparam int NUM_CLASSES = NUM_TYPES + 1;
    localparam int MAX_RANGES  = 4;
    localparam int IMPL_CLS    = NUM_TYPES;

    typedef enum logic [2:0] {
        ST_BANK     = 3'd0,
        ST_MSLICE   = 3'd1,
        ST_CNODE    = 3'd2,
        ST_SUBSLICE = 3'd3,
        ST_PAIR     = 3'd4,
        ST_BASE     = 3'd5
    } steer_type_e;

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } addr_range_t;

    typedef struct packed {
        logic [ID_W-1:0] grp;
        logic [ID_W-1:0] inst;
    } target_t;

    // Range tables; an entry with hi == 0 terminates its class.
    function automatic addr_range_t range_entry(input int cls, input int idx);
        addr_range_t r;
        r = '0;
        case (cls)
            0: case (idx)
                0: r = '{24'h00B100, 24'h00B3FF};
                1: r = '{24'h008C80, 24'h008CFF};
                default: r = '0;
            endcase
            1: case (idx)
                0: r = '{24'h00DD00, 24'h00DDFF};
                1: r = '{24'h00E900, 24'h00EFFF};
                default: r = '0;
            endcase
            2: case (idx)
                0: r = '{24'h00B000, 24'h00B0FF};
                1: r = '{24'h00D880, 24'h00D8FF};
                default: r = '0;
            endcase
            3: case (idx)
                0: r = '{24'h005200, 24'h0052FF};
                1: r = '{24'h008140, 24'h00815F};
                2: r = '{24'h00DE80, 24'h00E8FF};
                default: r = '0;
            endcase
            4: case (idx)
                0: r = '{24'h000B00, 24'h000BFF};
                1: r = '{24'h001000, 24'h001FFF};
                default: r = '0;
            endcase
            5: case (idx)
                0: r = '{24'h004000, 24'h004AFF};
                1: r = '{24'h00B000, 24'h00B3FF};
                default: r = '0;
            endcase
            6: case (idx)
                0: r = '{24'h00C800, 24'h00CFFF};
                1: r = '{24'h00F000, 24'h00FFFF};
                2: r = '0;
                3: r = '{24'h002000, 24'h002FFF};
                default: r = '0;
            endcase
            default: r = '0;
        endcase
        return r;
    endfunction

    // An entry is live when neither it nor any earlier entry is a terminator.
    function automatic bit entry_live(input int cls, input int idx);
        bit live;
        live = 1'b1;
        for (int k = 0; k <= idx; k++) begin
            if (range_entry(cls, k).hi == '0) live = 1'b0;
        end
        return live;
    endfunction

    // Index of the lowest set bit; 0 for an empty vector.
    function automatic logic [5:0] lowest_set(input logic [31:0] v);
        logic [5:0] r;
        r = '0;
        for (int k = 31; k >= 0; k--) begin
            if (v[k]) r = 6'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/steer_range_match.sv
module steer_range_match
    import steer_pkg::*;
#(
    parameter int CLS = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic [MAX_RANGES-1:0] entry_hit;

    for (genvar g = 0; g < MAX_RANGES; g++) begin : g_entry
        localparam addr_range_t RNG = range_entry(CLS, g);
        if (entry_live(CLS, g)) begin : g_live
            assign entry_hit[g] = (addr >= RNG.lo) && (addr <= RNG.hi);
        end else begin : g_dead
            assign entry_hit[g] = 1'b0;
        end
    end

    assign hit = |entry_hit;

endmodule

// File: rtl/steer_target_calc.sv
module steer_target_calc
    import steer_pkg::*;
#(
    parameter int MS_W   = 4,
    parameter int BANK_W = 3,
    parameter int NODE_W = 8,
    parameter int SS_W   = 32
) (
    input  logic [MS_W-1:0]             mslice_en,
    input  logic [BANK_W-1:0]           bank_mask,
    input  logic [NODE_W-1:0]           node_en,
    input  logic [SS_W-1:0]             subslice_en,
    input  logic [1:0]                  grp_mode,
    output target_t [NUM_TYPES-1:0]     tgts,
    output logic                        fuse_bad
);

    logic [5:0] ms_idx;
    logic [5:0] node_idx;
    logic [5:0] ss_idx;
    logic [5:0] ss_grp;
    logic [5:0] ss_inst;

    assign ms_idx   = lowest_set(32'(mslice_en));
    assign node_idx = lowest_set(32'(node_en));
    assign ss_idx   = lowest_set(32'(subslice_en));

    // Constant divisors keep each arm a shallow fixed network.
    always_comb begin
        case (grp_mode)
            2'd1: begin
                ss_grp  = ss_idx / 6'd6;
                ss_inst = ss_idx % 6'd6;
            end
            2'd2: begin
                ss_grp  = ss_idx >> 3;
                ss_inst = ss_idx & 6'd7;
            end
            default: begin
                ss_grp  = ss_idx >> 2;
                ss_inst = ss_idx & 6'd3;
            end
        endcase
    end

    always_comb begin
        tgts = '0;
        tgts[ST_BANK].grp      = ID_W'(ms_idx);
        tgts[ST_BANK].inst     = bank_mask[0] ? '0 : ID_W'(2);
        tgts[ST_MSLICE].grp    = ID_W'(ms_idx);
        tgts[ST_CNODE].grp     = ID_W'({ms_idx, 1'b0});
        tgts[ST_SUBSLICE].grp  = ID_W'(ss_grp);
        tgts[ST_SUBSLICE].inst = ID_W'(ss_inst);
        tgts[ST_PAIR].grp      = ID_W'(node_idx >> 1);
        tgts[ST_PAIR].inst     = ID_W'(node_idx[0]);
    end

    assign fuse_bad = (mslice_en == '0) || (node_en == '0) || (subslice_en == '0);

endmodule

// File: rtl/steer_prio_sel.sv
module steer_prio_sel
    import steer_pkg::*;
(
    input  logic [NUM_CLASSES-1:0]  cls_hit,
    input  target_t [NUM_TYPES-1:0] tgts,
    input  logic [NUM_TYPES-1:0]    ready,
    output logic                    steer_req,
    output logic [ID_W-1:0]         grp_id,
    output logic [ID_W-1:0]         inst_id,
    output logic                    warn
);

    always_comb begin
        logic found;
        found     = 1'b0;
        steer_req = 1'b1;
        grp_id    = '0;
        inst_id   = '0;
        warn      = 1'b1;
        for (int c = 0; c < NUM_TYPES; c++) begin
            if (!found && cls_hit[c]) begin
                found   = 1'b1;
                grp_id  = tgts[c].grp;
                inst_id = tgts[c].inst;
                warn    = !ready[c];
            end
        end
        if (!found && cls_hit[IMPL_CLS]) begin
            steer_req = 1'b0;
            warn      = 1'b0;
        end
    end

endmodule

// File: rtl/steer_resolver.sv
module steer_resolver
    import steer_pkg::*;
#(
    parameter int MS_W   = 4,
    parameter int BANK_W = 3,
    parameter int NODE_W = 8,
    parameter int SS_W   = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 init_stb,
    input  logic [MS_W-1:0]      mslice_en,
    input  logic [BANK_W-1:0]    bank_mask,
    input  logic [NODE_W-1:0]    node_en,
    input  logic [SS_W-1:0]      subslice_en,
    input  logic [1:0]           grp_mode,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 steer_req,
    output logic [ID_W-1:0]      grp_id,
    output logic [ID_W-1:0]      inst_id,
    output logic                 warn,
    output logic                 fuse_err
);

    localparam logic [NUM_TYPES-1:0] READY_AT_RESET = NUM_TYPES'(1) << ST_BASE;

    target_t [NUM_TYPES-1:0] next_tgts;
    target_t [NUM_TYPES-1:0] tgt_q;
    logic    [NUM_TYPES-1:0] ready_q;
    logic                    next_bad;
    logic                    fuse_q;
    logic [NUM_CLASSES-1:0]  cls_hit;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        steer_range_match #(.CLS(c)) u_match (
            .addr (addr),
            .hit  (cls_hit[c])
        );
    end

    steer_target_calc #(
        .MS_W   (MS_W),
        .BANK_W (BANK_W),
        .NODE_W (NODE_W),
        .SS_W   (SS_W)
    ) u_calc (
        .mslice_en   (mslice_en),
        .bank_mask   (bank_mask),
        .node_en     (node_en),
        .subslice_en (subslice_en),
        .grp_mode    (grp_mode),
        .tgts        (next_tgts),
        .fuse_bad    (next_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q   <= '0;
            ready_q <= READY_AT_RESET;
            fuse_q  <= 1'b0;
        end else if (init_stb) begin
            tgt_q   <= next_tgts;
            ready_q <= '1;
            fuse_q  <= next_bad;
        end
    end

    steer_prio_sel u_sel (
        .cls_hit   (cls_hit),
        .tgts      (tgt_q),
        .ready     (ready_q),
        .steer_req (steer_req),
        .grp_id    (grp_id),
        .inst_id   (inst_id),
        .warn      (warn)
    );

    assign fuse_err = fuse_q;

endmodule

// File: rtl/steer_resolver_chk.sv
module steer_resolver_chk
    import steer_pkg::*;
#(
    parameter int MS_W   = 4,
    parameter int NODE_W = 8,
    parameter int SS_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_stb,
    input  logic [MS_W-1:0]   mslice_en,
    input  logic [NODE_W-1:0] node_en,
    input  logic [SS_W-1:0]   subslice_en,
    input  logic              steer_req,
    input  logic [ID_W-1:0]   grp_id,
    input  logic [ID_W-1:0]   inst_id,
    input  logic              warn,
    input  logic              fuse_err
);

    logic seen_init;

    always_ff @(posedge clk) begin
        if (rst) seen_init <= 1'b0;
        else if (init_stb) seen_init <= 1'b1;
    end

    p_implicit_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !steer_req |-> (!warn && grp_id == '0 && inst_id == '0));

    p_nomatch_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (seen_init && warn) |-> (steer_req && grp_id == '0 && inst_id == '0));

    p_fuse_empty_r11: assert property (@(posedge clk) disable iff (rst)
        (init_stb && (mslice_en == '0 || node_en == '0 || subslice_en == '0)) |=> fuse_err);

    p_fuse_clean_r11: assert property (@(posedge clk) disable iff (rst)
        (init_stb && mslice_en != '0 && node_en != '0 && subslice_en != '0) |=> !fuse_err);

    p_fuse_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !init_stb |=> $stable(fuse_err));

endmodule

bind steer_resolver steer_resolver_chk #(
    .MS_W   (MS_W),
    .NODE_W (NODE_W),
    .SS_W   (SS_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .init_stb    (init_stb),
    .mslice_en   (mslice_en),
    .node_en     (node_en),
    .subslice_en (subslice_en),
    .steer_req   (steer_req),
    .grp_id      (grp_id),
    .inst_id     (inst_id),
    .warn        (warn),
    .fuse_err    (fuse_err)
);

// File: tb/steer_resolver_tb.sv
module steer_resolver_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_stb = 1'b0;
    logic [3:0]  mslice_en = '0;
    logic [2:0]  bank_mask = '0;
    logic [7:0]  node_en = '0;
    logic [31:0] subslice_en = '0;
    logic [1:0]  grp_mode = '0;
    logic [23:0] addr = '0;
    logic        steer_req;
    logic [7:0]  grp_id;
    logic [7:0]  inst_id;
    logic        warn;
    logic        fuse_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // Bench copy of the range tables from the requirements.
    logic [23:0] blo [7][4];
    logic [23:0] bhi [7][4];
    int  exp_g [6];
    int  exp_i [6];
    bit  exp_rdy [6];
    bit  exp_fuse;

    always #(CLK_PERIOD/2) clk = ~clk;

    steer_resolver u_dut (
        .clk(clk), .rst(rst), .init_stb(init_stb), .mslice_en(mslice_en),
        .bank_mask(bank_mask), .node_en(node_en), .subslice_en(subslice_en),
        .grp_mode(grp_mode), .addr(addr), .steer_req(steer_req),
        .grp_id(grp_id), .inst_id(inst_id), .warn(warn), .fuse_err(fuse_err)
    );

    task automatic set_rng(input int c, input int k, input logic [23:0] lo, input logic [23:0] hi);
        blo[c][k] = lo;
        bhi[c][k] = hi;
    endtask

    function automatic int ffs(input logic [31:0] v);
        for (int k = 0; k < 32; k++) if (v[k]) return k;
        return 0;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Lookup model: returns {steer, warn, grp, inst}.
    task automatic model(input logic [23:0] a, output bit s, output bit w,
                         output int g, output int i);
        s = 1'b1; w = 1'b1; g = 0; i = 0;
        for (int c = 0; c < 6; c++) begin
            for (int k = 0; k < 4; k++) begin
                if (bhi[c][k] == 0) break;
                if (a >= blo[c][k] && a <= bhi[c][k]) begin
                    g = exp_g[c]; i = exp_i[c]; w = !exp_rdy[c];
                    return;
                end
            end
        end
        for (int k = 0; k < 4; k++) begin
            if (bhi[6][k] == 0) break;
            if (a >= blo[6][k] && a <= bhi[6][k]) begin
                s = 1'b0; w = 1'b0;
                return;
            end
        end
    endtask

    task automatic lookup(input logic [23:0] a, input string tag);
        bit s, w;
        int g, i;
        model(a, s, w, g, i);
        @(negedge clk);
        addr = a;
        #1;
        n_checks++;
        if (steer_req !== s || warn !== w || grp_id !== 8'(g) || inst_id !== 8'(i)) begin
            n_fails++;
            $display("FAIL %s: addr 0x%06h actual s=%0b w=%0b g=%0d i=%0d expected s=%0b w=%0b g=%0d i=%0d",
                     tag, a, steer_req, warn, grp_id, inst_id, s, w, g, i);
        end
    endtask

    task automatic do_init(input logic [3:0] ms, input logic [2:0] bk, input logic [7:0] nd,
                           input logic [31:0] ss, input logic [1:0] md);
        int msi, p, d, sel;
        @(negedge clk);
        mslice_en = ms; bank_mask = bk; node_en = nd; subslice_en = ss; grp_mode = md;
        init_stb = 1'b1;
        @(negedge clk);
        init_stb = 1'b0;
        msi = ffs(32'(ms));
        p = (md == 2'd1) ? 6 : (md == 2'd2) ? 8 : 4;
        d = ffs(ss);
        sel = ffs(32'(nd));
        exp_g[0] = msi;      exp_i[0] = bk[0] ? 0 : 2;
        exp_g[1] = msi;      exp_i[1] = 0;
        exp_g[2] = msi * 2;  exp_i[2] = 0;
        exp_g[3] = d / p;    exp_i[3] = d % p;
        exp_g[4] = sel / 2;  exp_i[4] = sel % 2;
        exp_g[5] = 0;        exp_i[5] = 0;
        for (int c = 0; c < 6; c++) exp_rdy[c] = 1'b1;
        exp_fuse = (ms == 0) || (nd == 0) || (ss == 0);
        #1;
        chk("R11 fuse_err", int'(fuse_err), int'(exp_fuse));
    endtask

    function automatic logic [23:0] pick_addr();
        int c, k, o;
        if ($urandom % 4 == 0) return 24'($urandom % 32'h20000);
        c = $urandom % 7;
        k = $urandom % 4;
        if (bhi[c][k] == 0) return 24'($urandom % 32'h20000);
        o = $urandom % 5;
        case (o)
            0: return blo[c][k] - 24'd1;
            1: return blo[c][k];
            2: return bhi[c][k];
            3: return bhi[c][k] + 24'd1;
            default: return blo[c][k] + 24'((bhi[c][k] - blo[c][k]) / 2);
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        for (int c = 0; c < 7; c++)
            for (int k = 0; k < 4; k++) set_rng(c, k, 24'h0, 24'h0);
        set_rng(0, 0, 24'h00B100, 24'h00B3FF); set_rng(0, 1, 24'h008C80, 24'h008CFF);
        set_rng(1, 0, 24'h00DD00, 24'h00DDFF); set_rng(1, 1, 24'h00E900, 24'h00EFFF);
        set_rng(2, 0, 24'h00B000, 24'h00B0FF); set_rng(2, 1, 24'h00D880, 24'h00D8FF);
        set_rng(3, 0, 24'h005200, 24'h0052FF); set_rng(3, 1, 24'h008140, 24'h00815F);
        set_rng(3, 2, 24'h00DE80, 24'h00E8FF);
        set_rng(4, 0, 24'h000B00, 24'h000BFF); set_rng(4, 1, 24'h001000, 24'h001FFF);
        set_rng(5, 0, 24'h004000, 24'h004AFF); set_rng(5, 1, 24'h00B000, 24'h00B3FF);
        set_rng(6, 0, 24'h00C800, 24'h00CFFF); set_rng(6, 1, 24'h00F000, 24'h00FFFF);
        set_rng(6, 3, 24'h002000, 24'h002FFF); // dead: follows terminator
        for (int c = 0; c < 6; c++) begin
            exp_g[c] = 0; exp_i[c] = 0; exp_rdy[c] = (c == 5);
        end
        exp_fuse = 1'b0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11 reset fuse_err", int'(fuse_err), 0);

        // R5: before init only base is ready
        lookup(24'h005210, "R5 subslice pre-init warns");
        lookup(24'h004100, "R5 base pre-init quiet");
        chk("R5 pre-init warn", int'(warn), 0);
        lookup(24'h00DD40, "R5 mslice pre-init warns");
        chk("R5 pre-init warn flag", int'(warn), 1);

        // R6 R7 R8 R9 R10 directed
        do_init(4'b0100, 3'b010, 8'b0000_1100, 32'h0000_2000, 2'd1);
        lookup(24'h00DD10, "R6 mslice");
        chk("R6 mslice grp", int'(grp_id), 2);
        lookup(24'h00D8FF, "R7 cnode upper bound");
        chk("R7 cnode grp", int'(grp_id), 4);
        lookup(24'h00B200, "R8 bank");
        chk("R8 bank inst", int'(inst_id), 2);
        lookup(24'h000B00, "R9 pair lower bound");
        chk("R9 pair grp", int'(grp_id), 1);
        lookup(24'h008150, "R10 subslice mode6");
        chk("R10 subslice grp", int'(grp_id), 2);
        chk("R10 subslice inst", int'(inst_id), 1);

        // R2 priority on overlapping ranges
        lookup(24'h00B050, "R2 cnode beats base");
        chk("R2 overlap grp", int'(grp_id), 4);
        lookup(24'h00B3FF, "R2 bank beats base");
        // R1 bounds and terminator
        lookup(24'h0052FF, "R1 inclusive hi");
        lookup(24'h005300, "R1 past hi");
        lookup(24'h002100, "R1 dead entry after terminator");
        chk("R4 dead entry warns", int'(warn), 1);
        // R3 implicit
        lookup(24'h00C900, "R3 implicit");
        chk("R3 steer_req", int'(steer_req), 0);

        // R12: mask change without strobe
        @(negedge clk);
        mslice_en = 4'b0001; node_en = 8'h01; subslice_en = 32'h1; bank_mask = 3'b001;
        lookup(24'h00DD10, "R12 mslice held");
        chk("R12 held grp", int'(grp_id), 2);
        chk("R12 fuse held", int'(fuse_err), 0);

        // R10 other modes, R9 high sel, R8 bit0
        do_init(4'b1000, 3'b001, 8'b1000_0000, 32'h0000_2000, 2'd2);
        lookup(24'h008140, "R10 mode8");
        chk("R10 mode8 inst", int'(inst_id), 5);
        lookup(24'h001800, "R9 sel7");
        chk("R9 sel7 inst", int'(inst_id), 1);
        lookup(24'h008C80, "R8 bank bit0");
        chk("R8 bank bit0 inst", int'(inst_id), 0);
        do_init(4'b0010, 3'b011, 8'h02, 32'h0000_2000, 2'd3);
        lookup(24'h00E000, "R10 mode3 as 4");
        chk("R10 mode3 grp", int'(grp_id), 3);

        // R11 empty masks
        do_init(4'b0000, 3'b000, 8'h00, 32'h0, 2'd0);
        lookup(24'h00E950, "R11 empty mslice gives 0");
        lookup(24'h005400, "R4 no match");

        // random
        for (int r = 0; r < 25; r++) begin
            logic [3:0]  ms;
            logic [7:0]  nd;
            logic [31:0] ss;
            ms = 4'($urandom);
            nd = 8'($urandom);
            ss = $urandom;
            if ($urandom % 4 == 0) ss = ss & 32'hFFFF_0000;
            do_init(ms, 3'($urandom), nd, ss, 2'($urandom));
            for (int q = 0; q < 80; q++) lookup(pick_addr(), "R2 random lookup");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule